// File: doc/BRIEF.md
# DDR3 Command and Address Decoder

This block watches the command and address pins of a DDR3 memory bus and turns each rising clock into one decoded command. It reports the command type together with its qualifiers: target bank, row, column, auto-precharge request and burst-chop request. The rule for each qualifier depends on the command, because address bits 10 and 12 change meaning from one command to another.

The block also tracks which of the banks hold an open row. An Activate opens a bank. A Precharge closes one bank or all of them. A Read or Write that asks for auto-precharge closes its bank a fixed number of clocks later. This record drives an error flag for accesses that break the open/closed rules. The block is meant for a bus monitor or a memory model front end. It captures no data and enforces no timing parameters.

Top module: `ddr_cmd_decoder`

## Requirements
- R1: While `cs_n` is high at a clock edge, the reported command is Deselect (code 0), whatever the other command pins carry. No error is raised and the bank state is unchanged.
- R2: With `cs_n` low, `{ras_n,cas_n,we_n}` decodes to these codes on `cmd_o`: 111 → NOP (1), 011 → Activate (2), 101 → Read (3), 100 → Write (4), 010 → Precharge (5) or Precharge-All (6), 000 → Mode Register Set (7), 001 → Refresh (8), 110 → Other (9).
- R3: Every output is registered. A command sampled at clock edge k appears on the outputs right after edge k and holds until edge k+1.
- R4: `bank_o` carries `ba` for Activate, Read, Write, Precharge and Mode Register Set, and is 0 otherwise. `row_o` carries all 13 address bits for Activate only. `col_o` carries `addr[9:0]` for Read and Write only. Each field is 0 when it does not apply.
- R5: `auto_pre_o` equals `addr[10]` on Read and Write, and is 0 for every other command.
- R6: `chop_o` equals the inverse of `addr[12]` on Read and Write, so a low bit 12 requests a chopped burst. It is 0 for every other command.
- R7: On Precharge, `addr[10]` low gives code 5, which closes only bank `ba`. `addr[10]` high gives code 6, which closes every bank.
- R8: An Activate to a closed bank sets bit `ba` of `bank_open_o` at the same edge that reports the command. An Activate to an open bank changes no flag.
- R9: Precharge (code 5) clears only the flag of its bank. Precharge-All (code 6) clears all eight flags.
- R10: A Read or Write with `addr[10]` high to an open bank clears that bank's flag AP_LAT edges after the command edge (AP_LAT = 4 by default). A later auto-precharge access to the same bank restarts the count. A Precharge of that bank cancels the count.
- R11: `err_o` is raised with a Read or Write whose bank is closed before the command.
- R12: `err_o` is raised with an Activate whose bank is already open before the command.
- R13: `err_o` is raised with a Mode Register Set or Refresh while any bank is open. With all banks closed these commands raise no error.
- R14: While `rst_n` is low, every output is 0 and all banks are closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command pin, active low |
| cas_n | input | 1 | Column strobe command pin, active low |
| we_n | input | 1 | Write enable command pin, active low |
| ba | input | 3 | Bank address |
| addr | input | 13 | Address bus (row, column, bit 10 and bit 12 qualifiers) |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | 3 | Target bank or mode register |
| row_o | output | 13 | Row address of an Activate |
| col_o | output | 10 | Column address of a Read or Write |
| auto_pre_o | output | 1 | Auto-precharge requested |
| chop_o | output | 1 | Burst chop requested |
| err_o | output | 1 | Illegal command for the current bank state |
| bank_open_o | output | 8 | Open flag per bank |

## Verification
The decoded command, its qualifiers and the error flag for a command all appear one clock edge after the command is driven. The open flags follow at that same edge, except for an auto-precharge close, which comes AP_LAT edges after the access. The bench drives each command on a falling edge. It steps a behavioural model once per rising edge: the model decides legality from the state before the command, then runs the auto-precharge countdowns, then applies the command. The bench compares every output on the following falling edge, so each result is read in the one cycle it belongs to.

// File: rtl/ddr_dec_pkg.sv
package ddr_dec_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL = 4'd0,
        CMD_NOP   = 4'd1,
        CMD_ACT   = 4'd2,
        CMD_RD    = 4'd3,
        CMD_WR    = 4'd4,
        CMD_PRE   = 4'd5,
        CMD_PREA  = 4'd6,
        CMD_MRS   = 4'd7,
        CMD_REF   = 4'd8,
        CMD_OTHER = 4'd9
    } cmd_t;

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
    import ddr_dec_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic all_sel,
    output cmd_t cmd_o
);

    always_comb begin
        if (cs_n) begin
            cmd_o = CMD_DESEL;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  cmd_o = CMD_NOP;
                3'b011:  cmd_o = CMD_ACT;
                3'b101:  cmd_o = CMD_RD;
                3'b100:  cmd_o = CMD_WR;
                3'b010:  cmd_o = all_sel ? CMD_PREA : CMD_PRE;
                3'b001:  cmd_o = CMD_REF;
                3'b000:  cmd_o = CMD_MRS;
                default: cmd_o = CMD_OTHER;
            endcase
        end
    end

endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker
    import ddr_dec_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int AP_LAT = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  cmd_t                    cmd_i,
    input  logic [BANK_W-1:0]       bank_i,
    input  logic                    ap_i,
    output logic [(1<<BANK_W)-1:0]  open_o,
    output logic                    err_o
);

    localparam int NB    = 1 << BANK_W;
    localparam int CNT_W = $clog2(AP_LAT + 1);

    typedef struct packed {
        logic [NB-1:0]            open;
        logic [NB-1:0][CNT_W-1:0] cnt;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [NB-1:0] expire;

    // one expiry detector per bank
    for (genvar g = 0; g < NB; g++) begin : g_expire
        assign expire[g] = (trk_q.cnt[g] == CNT_W'(1));
    end

    always_comb begin
        trk_d = trk_q;
        for (int b = 0; b < NB; b++) begin
            if (trk_q.cnt[b] != '0) begin
                trk_d.cnt[b] = trk_q.cnt[b] - CNT_W'(1);
                if (expire[b]) begin
                    trk_d.open[b] = 1'b0;
                end
            end
        end
        case (cmd_i)
            CMD_ACT: begin
                if (!trk_q.open[bank_i]) begin
                    trk_d.open[bank_i] = 1'b1;
                end
            end
            CMD_PRE: begin
                trk_d.open[bank_i] = 1'b0;
                trk_d.cnt[bank_i]  = '0;
            end
            CMD_PREA: begin
                trk_d.open = '0;
                trk_d.cnt  = '0;
            end
            CMD_RD, CMD_WR: begin
                if (trk_q.open[bank_i] && ap_i) begin
                    trk_d.open[bank_i] = 1'b1;
                    trk_d.cnt[bank_i]  = CNT_W'(AP_LAT);
                end
            end
            default: ;
        endcase
    end

    always_comb begin
        case (cmd_i)
            CMD_RD, CMD_WR:   err_o = !trk_q.open[bank_i];
            CMD_ACT:          err_o = trk_q.open[bank_i];
            CMD_MRS, CMD_REF: err_o = |trk_q.open;
            default:          err_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign open_o = trk_q.open;

endmodule

// File: rtl/ddr_cmd_decoder.sv
module ddr_cmd_decoder
    import ddr_dec_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10,
    parameter int AP_BIT = 10,
    parameter int BC_BIT = 12,
    parameter int AP_LAT = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic [BANK_W-1:0]      ba,
    input  logic [ROW_W-1:0]       addr,
    output logic [3:0]             cmd_o,
    output logic [BANK_W-1:0]      bank_o,
    output logic [ROW_W-1:0]       row_o,
    output logic [COL_W-1:0]       col_o,
    output logic                   auto_pre_o,
    output logic                   chop_o,
    output logic                   err_o,
    output logic [(1<<BANK_W)-1:0] bank_open_o
);

    localparam int NB = 1 << BANK_W;

    typedef struct packed {
        cmd_t              cmd;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              ap;
        logic              chop;
        logic              err;
    } out_t;

    cmd_t          cmd_now;
    logic          trk_err;
    logic [NB-1:0] open_flags;
    out_t          out_d, out_q;

    ddr_cmd_decode u_decode (
        .cs_n    (cs_n),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .all_sel (addr[AP_BIT]),
        .cmd_o   (cmd_now)
    );

    ddr_bank_tracker #(
        .BANK_W (BANK_W),
        .AP_LAT (AP_LAT)
    ) u_tracker (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_i  (cmd_now),
        .bank_i (ba),
        .ap_i   (addr[AP_BIT]),
        .open_o (open_flags),
        .err_o  (trk_err)
    );

    always_comb begin
        out_d     = '0;
        out_d.cmd = cmd_now;
        out_d.err = trk_err;
        case (cmd_now)
            CMD_ACT: begin
                out_d.bank = ba;
                out_d.row  = addr;
            end
            CMD_RD, CMD_WR: begin
                out_d.bank = ba;
                out_d.col  = addr[COL_W-1:0];
                out_d.ap   = addr[AP_BIT];
                out_d.chop = !addr[BC_BIT];
            end
            CMD_PRE, CMD_MRS: begin
                out_d.bank = ba;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign cmd_o       = out_q.cmd;
    assign bank_o      = out_q.bank;
    assign row_o       = out_q.row;
    assign col_o       = out_q.col;
    assign auto_pre_o  = out_q.ap;
    assign chop_o      = out_q.chop;
    assign err_o       = out_q.err;
    assign bank_open_o = open_flags;

endmodule

// File: rtl/ddr_cmd_decoder_chk.sv
module ddr_cmd_decoder_chk #(
    parameter int BANK_W = 3,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cs_n,
    input logic                   ras_n,
    input logic                   cas_n,
    input logic                   we_n,
    input logic [BANK_W-1:0]      ba,
    input logic [3:0]             cmd_o,
    input logic [ROW_W-1:0]       row_o,
    input logic [COL_W-1:0]       col_o,
    input logic                   auto_pre_o,
    input logic                   chop_o,
    input logic                   err_o,
    input logic [(1<<BANK_W)-1:0] bank_open_o
);

    logic [2:0] pins;
    logic       act_in, rdwr_in, pre_pin, mrs_ref_in;

    assign pins       = {ras_n, cas_n, we_n};
    assign act_in     = !cs_n && (pins == 3'b011);
    assign rdwr_in    = !cs_n && (pins == 3'b101 || pins == 3'b100);
    assign pre_pin    = !cs_n && (pins == 3'b010);
    assign mrs_ref_in = !cs_n && (pins == 3'b000 || pins == 3'b001);

    // R1
    a_r1_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (cmd_o == 4'd0) && !err_o);

    // R8
    a_r8_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
        act_in |=> bank_open_o[$past(ba)]);

    // R9
    a_r9_prea_all: assert property (@(posedge clk) disable iff (!rst_n)
        pre_pin |=> (cmd_o != 4'd6) || (bank_open_o == '0));

    // R11
    a_r11_rdwr_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (rdwr_in && !bank_open_o[ba]) |=> err_o);

    // R13
    a_r13_mrs_ref_open: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_ref_in && (|bank_open_o)) |=> err_o);

    // R5 and R6
    a_r5_r6_qual_scope: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_o == 4'd3 || cmd_o == 4'd4) |-> !auto_pre_o && !chop_o);

    // R4
    a_r4_field_scope: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_o != 4'd2) |-> (row_o == '0)) and
        (!(cmd_o == 4'd3 || cmd_o == 4'd4) |-> (col_o == '0)));

endmodule

bind ddr_cmd_decoder ddr_cmd_decoder_chk #(
    .BANK_W (BANK_W),
    .ROW_W  (ROW_W),
    .COL_W  (COL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .ba          (ba),
    .cmd_o       (cmd_o),
    .row_o       (row_o),
    .col_o       (col_o),
    .auto_pre_o  (auto_pre_o),
    .chop_o      (chop_o),
    .err_o       (err_o),
    .bank_open_o (bank_open_o)
);

// File: tb/ddr_cmd_decoder_test.sv
module ddr_cmd_decoder_test;

    localparam int CLK_PERIOD = 10;
    localparam int AP_LAT     = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [2:0]  ba = '0;
    logic [12:0] addr = '0;
    logic [3:0]  cmd_o;
    logic [2:0]  bank_o;
    logic [12:0] row_o;
    logic [9:0]  col_o;
    logic        auto_pre_o, chop_o, err_o;
    logic [7:0]  bank_open_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    bit m_open [8];
    int m_cnt  [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    ddr_cmd_decoder #(.AP_LAT(AP_LAT)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr(addr), .cmd_o(cmd_o), .bank_o(bank_o),
        .row_o(row_o), .col_o(col_o), .auto_pre_o(auto_pre_o), .chop_o(chop_o),
        .err_o(err_o), .bank_open_o(bank_open_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit [7:0] open_vec();
        bit [7:0] v;
        for (int i = 0; i < 8; i++) v[i] = m_open[i];
        return v;
    endfunction

    // drive at a falling edge, step the model, compare at the next falling edge
    task automatic issue(input bit cs, input bit [2:0] rcw, input bit [2:0] b, input bit [12:0] a);
        int  code;
        bit  e_err, any, rdwr;
        bit  pre_open [8];
        logic [2:0]  e_bank;
        logic [12:0] e_row;
        logic [9:0]  e_col;
        logic        e_ap, e_chop;
        string       etag;
        cs_n = cs; {ras_n, cas_n, we_n} = rcw; ba = b; addr = a;
        if (cs) code = 0;
        else case (rcw)
            3'b111: code = 1;
            3'b011: code = 2;
            3'b101: code = 3;
            3'b100: code = 4;
            3'b010: code = a[10] ? 6 : 5;
            3'b000: code = 7;
            3'b001: code = 8;
            default: code = 9;
        endcase
        any = 0;
        for (int i = 0; i < 8; i++) begin pre_open[i] = m_open[i]; any |= m_open[i]; end
        rdwr = (code == 3 || code == 4);
        e_err = 0; etag = "R1";
        if (rdwr)                      begin e_err = !pre_open[b]; etag = "R11"; end
        else if (code == 2)            begin e_err = pre_open[b];  etag = "R12"; end
        else if (code == 7 || code == 8) begin e_err = any;        etag = "R13"; end
        e_bank = (code == 2 || rdwr || code == 5 || code == 7) ? b : 3'd0;
        e_row  = (code == 2) ? a : 13'd0;
        e_col  = rdwr ? a[9:0] : 10'd0;
        e_ap   = rdwr ? a[10] : 1'b0;
        e_chop = rdwr ? !a[12] : 1'b0;
        // countdowns first, command second
        for (int i = 0; i < 8; i++) begin
            if (m_cnt[i] > 0) begin
                m_cnt[i]--;
                if (m_cnt[i] == 0) m_open[i] = 0;
            end
        end
        case (code)
            2: if (!pre_open[b]) m_open[b] = 1;
            5: begin m_open[b] = 0; m_cnt[b] = 0; end
            6: for (int i = 0; i < 8; i++) begin m_open[i] = 0; m_cnt[i] = 0; end
            3, 4: if (pre_open[b] && a[10]) begin m_open[b] = 1; m_cnt[b] = AP_LAT; end
            default: ;
        endcase
        @(posedge clk);
        @(negedge clk);
        chk((code == 5 || code == 6) ? "R7 cmd" : "R2 R3 cmd", 32'(cmd_o), 32'(code));
        chk(etag, 32'(err_o), 32'(e_err));
        chk("R4 bank", 32'(bank_o), 32'(e_bank));
        chk("R4 row", 32'(row_o), 32'(e_row));
        chk("R4 col", 32'(col_o), 32'(e_col));
        chk("R5 autopre", 32'(auto_pre_o), 32'(e_ap));
        chk("R6 chop", 32'(chop_o), 32'(e_chop));
        chk("R8 R9 R10 open", 32'(bank_open_o), 32'(open_vec()));
    endtask

    localparam bit [2:0] P_NOP = 3'b111, P_ACT = 3'b011, P_RD = 3'b101, P_WR = 3'b100,
                         P_PRE = 3'b010, P_REF = 3'b001, P_MRS = 3'b000, P_OTH = 3'b110;

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin m_open[i] = 0; m_cnt[i] = 0; end
        // drive a command during reset: nothing may move (R14)
        cs_n = 1'b0; {ras_n, cas_n, we_n} = P_ACT; ba = 3'd4; addr = 13'h1FFF;
        repeat (3) @(negedge clk);
        chk("R14 cmd", 32'(cmd_o), 0);
        chk("R14 err", 32'(err_o), 0);
        chk("R14 row", 32'(row_o), 0);
        chk("R14 open", 32'(bank_open_o), 0);
        cs_n = 1'b1;
        rst_n = 1'b1;

        issue(0, P_NOP, 3'd0, 13'h0);
        issue(1, P_ACT, 3'd2, 13'h0123);       // R1 masked activate
        issue(1, P_MRS, 3'd1, 13'h1FFF);       // R1 masked
        issue(0, P_RD,  3'd2, 13'h0040);       // R11 closed bank
        issue(0, P_ACT, 3'd2, 13'h1ABC);       // R8 open, R4 row
        issue(0, P_ACT, 3'd2, 13'h0055);       // R12 already open
        issue(0, P_WR,  3'd2, 13'h1155);       // no AP, full burst
        issue(0, P_RD,  3'd2, 13'h03AA);       // R6 chop requested
        issue(0, P_MRS, 3'd3, 13'h0A00);       // R13 bank open
        issue(0, P_REF, 3'd0, 13'h0);          // R13 bank open
        issue(0, P_ACT, 3'd5, 13'h0777);
        issue(0, P_PRE, 3'd2, 13'h0000);       // R7 single, R9 only bank 2
        issue(0, P_RD,  3'd5, 13'h0410);       // R10 auto-precharge
        for (int i = 0; i < AP_LAT; i++) issue(0, P_NOP, 3'd0, 13'h0);
        issue(0, P_ACT, 3'd1, 13'h0001);
        issue(0, P_ACT, 3'd6, 13'h0006);
        issue(0, P_RD,  3'd1, 13'h1400);       // R10 start count
        issue(0, P_NOP, 3'd0, 13'h0);
        issue(0, P_WR,  3'd1, 13'h0401);       // R10 restart count
        issue(0, P_WR,  3'd6, 13'h0402);       // R10 AP on bank 6
        issue(0, P_PRE, 3'd6, 13'h0000);       // R10 cancel by precharge
        issue(0, P_ACT, 3'd6, 13'h0100);
        for (int i = 0; i < AP_LAT + 1; i++) issue(0, P_NOP, 3'd0, 13'h0);
        issue(0, P_PRE, 3'd0, 13'h0400);       // R7 all, R9 clears all
        issue(0, P_MRS, 3'd2, 13'h0123);       // R13 no error when closed
        issue(0, P_REF, 3'd0, 13'h0);
        issue(0, P_OTH, 3'd0, 13'h0);          // R2 other code
        for (int i = 0; i < 60; i++) begin
            issue((i % 7) == 0, 3'((i * 5) % 8), 3'((i * 3) % 8), 13'((i * 677) & 13'h1FFF));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule